// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block takes a 16-bit IEEE 754 half-precision operand and produces the equivalent 32-bit single-precision word. It does this by taking the sign, exponent and fraction fields apart and putting them back together in the wider layout. Every half-precision value is exact in single precision, so there is no rounding. The block raises no exception and has no flag outputs.

Exceptional values keep their exact bits. Infinities stay infinities. NaNs keep their full payload, and a signaling NaN is not quieted. This lets a fused multiply-add stage further down the datapath still choose among NaN operands by their signaling state. Subnormal half-precision inputs become normal single-precision numbers: the fraction is shifted left and the exponent is adjusted to match.

A flush-to-zero control replaces subnormal inputs with a zero that keeps the input sign. The result is registered, so it appears one clock after the operand is presented.

Top module: `hfw_widen`

## Requirements
- R1: The input is read as sign at bit 15, exponent at bits 14:10 and fraction at bits 9:0. The output is written as sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0. Output bits 12:0 are always zero, and output bit 31 always equals the input sign.
- R2: For an input exponent from 1 to 30, the output exponent is the input exponent plus 112. Output bits 22:13 equal the input fraction.
- R3: For an input exponent of 31, the output exponent is 255 and output bits 22:13 equal the input fraction. Infinities therefore stay infinities, and a NaN keeps output bit 22 equal to input bit 9, so a signaling NaN is not quieted.
- R4: An input with exponent 0 and fraction 0 produces a single-precision zero with the same sign, whatever the value of ftz_en.
- R5: With ftz_en low, an input with exponent 0 and a nonzero fraction is normalized. Let k be the left shift, from 1 to 10, that moves the fraction's leading one to bit 10. The output exponent is 113 minus k, and output bits 22:13 hold the shifted fraction with that leading one removed.
- R6: With ftz_en high, an input with exponent 0 and a nonzero fraction produces a zero that keeps the input sign. For all other inputs, ftz_en has no effect on the output.
- R7: single_out is registered. It shows the conversion of the half_in and ftz_en values sampled at the previous rising clock edge. While rst is high at a rising edge, the output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the result register |
| half_in | input | 16 | Half-precision operand |
| ftz_en | input | 1 | When high, subnormal operands become signed zero |
| single_out | output | 32 | Single-precision result, one cycle after the operand |

## Verification
The bench sweeps every one of the 65536 half-precision codes twice: once with flush-to-zero off and once with it on. Each result is compared against a behavioural model that normalizes subnormals one bit at a time in a loop. The sweep covers both signs of zero, all 1023 subnormal fractions of each sign (shift amounts 1 through 10), every normal exponent, both infinities, and quiet and signaling NaNs with many payloads. Comparing the two passes shows that flush-to-zero changes only the subnormal codes. Directed reset checks, both at start-up and in the middle of the run, confirm that the output clears and that the one-cycle latency holds.

// File: rtl/hfw_pkg.sv
package hfw_pkg;
  localparam int HALF_EXP_W    = 5;
  localparam int HALF_FRAC_W   = 10;
  localparam int SINGLE_EXP_W  = 8;
  localparam int SINGLE_FRAC_W = 23;

  localparam int HALF_W    = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SINGLE_W  = 1 + SINGLE_EXP_W + SINGLE_FRAC_W;
  localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SINGLE_BIAS = (1 << (SINGLE_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF   = SINGLE_BIAS - HALF_BIAS;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } fclass_e;
endpackage

// File: rtl/hfw_lzc.sv
module hfw_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  hit;
  logic [CW-1:0] cand [W];

  // One candidate per bit: leading-zero count if that bit is the top one
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == W - 1) begin : g_top
      assign hit[g] = vec_i[g];
    end else begin : g_low
      assign hit[g] = vec_i[g] & ~(|vec_i[W-1:g+1]);
    end
    assign cand[g] = CW'(W - 1 - g);
  end

  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (hit[i]) cnt_o = cand[i];
    end
  end
endmodule

// File: rtl/hfw_decode.sv
module hfw_decode
  import hfw_pkg::*;
#(
  parameter int HE = HALF_EXP_W,
  parameter int HF = HALF_FRAC_W,
  localparam int HW = 1 + HE + HF
) (
  input  logic [HW-1:0] word_i,
  output logic          sign_o,
  output logic [HE-1:0] exp_o,
  output logic [HF-1:0] frac_o,
  output fclass_e       cls_o
);
  assign sign_o = word_i[HW-1];
  assign exp_o  = word_i[HW-2:HF];
  assign frac_o = word_i[HF-1:0];

  always_comb begin
    if (&exp_o)           cls_o = CLS_SPECIAL;
    else if (|exp_o)      cls_o = CLS_NORMAL;
    else if (|frac_o)     cls_o = CLS_SUBNORM;
    else                  cls_o = CLS_ZERO;
  end
endmodule

// File: rtl/hfw_norm.sv
module hfw_norm #(
  parameter int HF        = 10,
  parameter int SE        = 8,
  parameter int BIAS_DIFF = 112
) (
  input  logic [HF-1:0] frac_i,
  output logic [SE-1:0] exp_o,
  output logic [HF-1:0] frac_o
);
  localparam int CW = $clog2(HF + 1);

  logic [CW-1:0] lead_zeros;
  logic [CW:0]   shift_amt;

  hfw_lzc #(.W(HF)) u_lzc (
    .vec_i (frac_i),
    .cnt_o (lead_zeros)
  );

  // Shift is lead_zeros + 1, so the leading one falls off the top
  assign shift_amt = {1'b0, lead_zeros} + 1'b1;

  always_comb begin
    frac_o = frac_i << shift_amt;
    exp_o  = SE'(BIAS_DIFF) - SE'(lead_zeros);
  end
endmodule

// File: rtl/hfw_widen.sv
module hfw_widen
  import hfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] half_in,
  input  logic        ftz_en,
  output logic [31:0] single_out
);
  localparam int PAD_W = SINGLE_FRAC_W - HALF_FRAC_W;

  logic                     h_sign;
  logic [HALF_EXP_W-1:0]    h_exp;
  logic [HALF_FRAC_W-1:0]   h_frac;
  fclass_e                  h_cls;
  logic [SINGLE_EXP_W-1:0]  sub_exp;
  logic [HALF_FRAC_W-1:0]   sub_frac;
  logic [SINGLE_EXP_W-1:0]  res_exp;
  logic [HALF_FRAC_W-1:0]   res_frac;
  logic [SINGLE_W-1:0]      res_word;

  hfw_decode #(.HE(HALF_EXP_W), .HF(HALF_FRAC_W)) u_decode (
    .word_i (half_in),
    .sign_o (h_sign),
    .exp_o  (h_exp),
    .frac_o (h_frac),
    .cls_o  (h_cls)
  );

  hfw_norm #(.HF(HALF_FRAC_W), .SE(SINGLE_EXP_W), .BIAS_DIFF(BIAS_DIFF)) u_norm (
    .frac_i (h_frac),
    .exp_o  (sub_exp),
    .frac_o (sub_frac)
  );

  always_comb begin
    unique case (h_cls)
      CLS_SPECIAL: begin
        res_exp  = '1;
        res_frac = h_frac;
      end
      CLS_NORMAL: begin
        res_exp  = SINGLE_EXP_W'(h_exp) + SINGLE_EXP_W'(BIAS_DIFF);
        res_frac = h_frac;
      end
      CLS_SUBNORM: begin
        res_exp  = ftz_en ? '0 : sub_exp;
        res_frac = ftz_en ? '0 : sub_frac;
      end
      default: begin
        res_exp  = '0;
        res_frac = '0;
      end
    endcase
    res_word = {h_sign, res_exp, res_frac, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) single_out <= '0;
    else     single_out <= res_word;
  end
endmodule

// File: rtl/hfw_chk.sv
module hfw_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] half_in,
  input logic        ftz_en,
  input logic [31:0] single_out
);
  // R7
  reset_zero_chk: assert property (@(posedge clk) rst |=> single_out == 32'h0);

  // R1
  low_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> single_out[12:0] == 13'h0);

  // R1
  sign_carry_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> single_out[31] == $past(half_in[15]));

  // R2
  norm_rebias_chk: assert property (@(posedge clk) disable iff (rst)
    (half_in[14:10] != 5'h00 && half_in[14:10] != 5'h1f) |=>
      (single_out[30:23] == 8'($past(half_in[14:10])) + 8'd112) &&
      (single_out[22:13] == $past(half_in[9:0])));

  // R3
  special_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (half_in[14:10] == 5'h1f) |=>
      (single_out[30:23] == 8'hff) && (single_out[22:13] == $past(half_in[9:0])));

  // R4
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (half_in[14:0] == 15'h0) |=> single_out[30:0] == 31'h0);

  // R5
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    (half_in[14:10] == 5'h00 && half_in[9:0] != 10'h0 && !ftz_en) |=>
      (single_out[30:23] >= 8'd103) && (single_out[30:23] <= 8'd112));

  // R6
  ftz_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (half_in[14:10] == 5'h00 && ftz_en) |=> single_out[30:0] == 31'h0);
endmodule

bind hfw_widen hfw_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .half_in    (half_in),
  .ftz_en     (ftz_en),
  .single_out (single_out)
);

// File: tb/hfw_widen_bench.sv
module hfw_widen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] half_in = 16'h0;
  logic        ftz_en = 1'b0;
  logic [31:0] single_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  hfw_widen u_hfw_widen (
    .clk        (clk),
    .rst        (rst),
    .half_in    (half_in),
    .ftz_en     (ftz_en),
    .single_out (single_out)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] ref_conv(input int h, input bit ftz);
    int s = (h >> 15) & 1;
    int e = (h >> 10) & 31;
    int f = h & 1023;
    int eo;
    int fo;
    if (e == 31) begin
      eo = 255; fo = f;
    end else if (e == 0) begin
      if (f == 0 || ftz) return {s[0], 31'h0};
      eo = 113; fo = f;
      while ((fo & 1024) == 0) begin
        fo = fo << 1;
        eo = eo - 1;
      end
      fo = fo & 1023;
    end else begin
      eo = e + 112; fo = f;
    end
    return {s[0], eo[7:0], fo[9:0], 13'h0};
  endfunction

  function automatic string tag_of(input int h, input bit ftz);
    int e = (h >> 10) & 31;
    int f = h & 1023;
    if (e == 31) return "R3";
    if (e != 0)  return "R2";
    if (f == 0)  return "R4";
    return ftz ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: half=%h ftz=%0b actual=%h expected=%h", req, half_in, ftz_en, act, exp);
    end
  endtask

  // Drive at negedge, result registered at next posedge, sample at next negedge
  task automatic apply(input int h, input bit ftz, input string req);
    half_in = h[15:0];
    ftz_en  = ftz;
    @(negedge clk);
    check(req, single_out, ref_conv(h, ftz));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 180000) begin
        fails++;
        $display("FAIL watchdog: actual=%0d cycles expected<=180000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R7: reset holds output at zero even with a nonzero operand
    half_in = 16'h7c00;
    repeat (3) @(negedge clk);
    check("R7", single_out, 32'h0);
    rst = 1'b0;

    // R1: directed field placement
    apply(16'h8000, 1'b0, "R1");
    apply(16'h3c00, 1'b0, "R1");
    apply(16'hc248, 1'b0, "R1");
    // R3: signaling NaN stays signaling, quiet NaN and infinities
    apply(16'h7c01, 1'b0, "R3");
    apply(16'hfe00, 1'b1, "R3");
    apply(16'hfc00, 1'b0, "R3");
    // R5: smallest and largest subnormal
    apply(16'h0001, 1'b0, "R5");
    apply(16'h83ff, 1'b0, "R5");
    // R6: flushed negative subnormal
    apply(16'h8001, 1'b1, "R6");

    // Full sweep with flush-to-zero off, then on
    for (int f = 0; f < 2; f++) begin
      for (int h = 0; h < 65536; h++) begin
        apply(h, f[0], tag_of(h, f[0]));
      end
    end

    // R7: mid-run reset clears output, then one-cycle latency resumes
    half_in = 16'h7bff;
    rst = 1'b1;
    @(negedge clk);
    check("R7", single_out, 32'h0);
    rst = 1'b0;
    apply(16'h7bff, 1'b0, "R7");

    finish_run();
  end
endmodule